// File: doc/BRIEF.md
# Configuration Frame Write and Readback Engine

This block collects configuration frames arriving as 128-bit beats, commits each completed frame into a small on-chip frame store at a running frame address, and later streams stored frames back out on request. A 5-bit command input switches the row power flag and the write and read enables. The frame address holds a block type and a frame index. After every commit it steps forward, moving to the next block type once the index passes the per-type last-frame limit. These limits arrive on a static configuration input.

Readback is started in one of two ways: by a frame count, which scans a linear range of addresses from the current frame address, or by a single-frame address. The scan leaves out addresses with no stored frame. Each stored frame goes out as a run of beats on a valid/ready stream that can be stalled. The store holds a parameterized number of entries. Each entry is picked by the low address bits and keeps the full address as a tag, so a later frame whose low bits match replaces the earlier one.

Top module: `cfg_frame_engine`

## Requirements
- R1: After reset `rd_valid` and `busy` are 0 and `frame_addr` is 0. Reset discards every stored frame and any partly collected frame, so a readback after reset emits nothing until new frames are written.
- R2: The block is configured only while some 20-bit limit in `frame_limits` is nonzero. The limit for block type k sits at bits [20k+19:20k]. While unconfigured, commands, frame address writes, data beats and readback triggers all have no effect.
- R3: Command codes on `cmd_code`: 1 sets the write enable, 2 sets row on, 3 clears row on, 4 sets the read enable, 5 clears both the write and read enables. Every other code has no effect. A beat is taken only when the block is configured, row on is set and the write enable is set.
- R4: Accepted beats collect in order. A gap between beats does not lose a partial frame. On the FRAME_BEATS-th accepted beat the frame is committed at `frame_addr`, and `frame_addr` then steps once. `frame_addr` changes only on a commit or on a frame address write, and the write takes priority.
- R5: `frame_addr` keeps the frame index in bits [19:0] and the block type in bits [22:20]. A step adds 1 to the index. If the new index is greater than the limit of the current block type, the index becomes 0 and the block type goes up by 1. At block type 6 or above the block type stays where it is.
- R6: A `count_wr` pulse, taken while the block is configured, row on is set and the read enable is set, scans floor(`count_data`/FRAME_BEATS) consecutive addresses starting at `frame_addr`. A count smaller than FRAME_BEATS emits nothing.
- R7: A `one_frame_wr` pulse under the same conditions reads exactly the address `one_frame_addr`. If both trigger pulses come in the same cycle, the count trigger wins.
- R8: An address is skipped without emitting beats if its store entry is empty or holds a frame committed at a different address. A stored frame is emitted as FRAME_BEATS beats, in the order the beats were received.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold their values. No beat is lost or repeated.
- R10: A readback trigger that comes while `busy` is high is ignored. `busy` is high from the edge that accepts a trigger until the scan has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_limits | input | 140 | Seven 20-bit last-frame limits, block type k in bits [20k+19:20k] |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 5 | Command code |
| frame_addr_wr | input | 1 | Load the frame address |
| frame_addr_in | input | 23 | New frame address |
| frame_addr | output | 23 | Current frame address |
| beat_valid | input | 1 | Data beat strobe |
| beat_data | input | 128 | Data beat, four 32-bit words |
| count_wr | input | 1 | Start a counted readback |
| count_data | input | 32 | Readback length in beats |
| one_frame_wr | input | 1 | Start a single-frame readback |
| one_frame_addr | input | 23 | Address of the single frame |
| busy | output | 1 | Readback scan in progress |
| rd_valid | output | 1 | Readback beat valid |
| rd_ready | input | 1 | Readback beat accepted |
| rd_data | output | 128 | Readback beat |

## Verification
The write path is tried with beats interleaved with row off, park and unknown codes, and with partial frames split across those gaps. This shows whether gating drops beats without losing collected ones. Commits are walked across block types with limits of 2, 1 and 0 and up to type 6, which separates a plain index step, a roll to the next type, an immediate roll past a zero limit, and saturation at the top type. Readback ranges mix hits, empty entries and entries taken over by an aliasing address, so the checks show skipping by tag and not by index. A stalled stream with a competing trigger checks that data is held and the second trigger is ignored.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
   localparam int IDX_W    = 20;
   localparam int BT_W     = 3;
   localparam int ADDR_W   = IDX_W + BT_W;
   localparam int NUM_BT   = 7;
   localparam int CMD_W    = 5;

   localparam logic [CMD_W-1:0] OP_WRITE_ON = 5'd1;
   localparam logic [CMD_W-1:0] OP_ROW_ON   = 5'd2;
   localparam logic [CMD_W-1:0] OP_ROW_OFF  = 5'd3;
   localparam logic [CMD_W-1:0] OP_READ_ON  = 5'd4;
   localparam logic [CMD_W-1:0] OP_PARK     = 5'd5;

   typedef logic [ADDR_W-1:0] faddr_t;
endpackage

// File: rtl/cfe_mode_ctrl.sv
module cfe_mode_ctrl
   import cfe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             configured,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_code,
   output logic             row_on,
   output logic             wr_en,
   output logic             rd_en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_on <= 1'b0;
         wr_en  <= 1'b0;
         rd_en  <= 1'b0;
      end else if (cmd_valid && configured) begin
         case (cmd_code)
            OP_WRITE_ON: wr_en  <= 1'b1;
            OP_ROW_ON:   row_on <= 1'b1;
            OP_ROW_OFF:  row_on <= 1'b0;
            OP_READ_ON:  rd_en  <= 1'b1;
            OP_PARK: begin
               wr_en <= 1'b0;
               rd_en <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cfe_addr_step.sv
module cfe_addr_step
   import cfe_pkg::*;
(
   input  faddr_t                    cur,
   input  logic [NUM_BT*IDX_W-1:0]   limits,
   output faddr_t                    nxt
);
   logic [IDX_W-1:0] lim_arr [NUM_BT];
   logic [IDX_W-1:0] lim_sel;
   logic [IDX_W:0]   idx_inc;
   logic [BT_W-1:0]  bt_cur;

   for (genvar k = 0; k < NUM_BT; k++) begin : g_lim
      assign lim_arr[k] = limits[k*IDX_W +: IDX_W];
   end

   assign bt_cur  = cur[ADDR_W-1:IDX_W];
   assign idx_inc = {1'b0, cur[IDX_W-1:0]} + 1'b1;

   always_comb begin
      lim_sel = '0;
      for (int k = 0; k < NUM_BT; k++)
         if (bt_cur == BT_W'(k)) lim_sel = lim_arr[k];
   end

   always_comb begin
      if (idx_inc > {1'b0, lim_sel}) begin
         if (bt_cur >= BT_W'(NUM_BT - 1))
            nxt = {bt_cur, {IDX_W{1'b0}}};
         else
            nxt = {bt_cur + 1'b1, {IDX_W{1'b0}}};
      end else begin
         nxt = {bt_cur, idx_inc[IDX_W-1:0]};
      end
   end
endmodule

// File: rtl/cfe_frame_store.sv
module cfe_frame_store
   import cfe_pkg::*;
#(
   parameter int BEAT_W      = 128,
   parameter int FRAME_BEATS = 4,
   parameter int DEPTH       = 8,
   localparam int FRAME_W    = BEAT_W * FRAME_BEATS,
   localparam int SIDX_W     = $clog2(DEPTH),
   localparam int BSEL_W     = (FRAME_BEATS > 1) ? $clog2(FRAME_BEATS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  faddr_t            wr_addr,
   input  logic [FRAME_W-1:0] wr_frame,
   input  faddr_t            rd_addr,
   input  logic [BSEL_W-1:0] rd_beat,
   output logic              rd_hit,
   output logic [BEAT_W-1:0] rd_data
);
   logic [FRAME_W-1:0] mem   [DEPTH];
   faddr_t             tag   [DEPTH];
   logic [DEPTH-1:0]   valid;

   logic [SIDX_W-1:0] w_idx, r_idx;
   assign w_idx = wr_addr[SIDX_W-1:0];
   assign r_idx = rd_addr[SIDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)     valid <= '0;
      else if (wr_en) valid[w_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[w_idx] <= wr_frame;
         tag[w_idx] <= wr_addr;
      end
   end

   assign rd_hit  = valid[r_idx] && (tag[r_idx] == rd_addr);
   assign rd_data = mem[r_idx][rd_beat*BEAT_W +: BEAT_W];
endmodule

// File: rtl/cfe_readout.sv
module cfe_readout
   import cfe_pkg::*;
#(
   parameter int FRAME_BEATS = 4,
   parameter int CNT_W       = 32,
   localparam int BSEL_W     = (FRAME_BEATS > 1) ? $clog2(FRAME_BEATS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  faddr_t            start_addr,
   input  logic [CNT_W-1:0]  n_frames,
   input  logic              hit,
   input  logic              rd_ready,
   output faddr_t            look_addr,
   output logic [BSEL_W-1:0] look_beat,
   output logic              rd_valid,
   output logic              busy
);
   localparam logic [BSEL_W-1:0] LAST_BEAT = BSEL_W'(FRAME_BEATS - 1);

   logic [CNT_W-1:0] remain;
   logic             more;

   assign more     = (remain != '0);
   assign rd_valid = busy && more && hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         remain    <= '0;
         look_addr <= '0;
         look_beat <= '0;
      end else if (!busy) begin
         if (start) begin
            busy      <= 1'b1;
            look_addr <= start_addr;
            remain    <= n_frames;
            look_beat <= '0;
         end
      end else if (!more) begin
         busy <= 1'b0;
      end else if (!hit) begin
         look_addr <= look_addr + 1'b1;
         remain    <= remain - 1'b1;
         look_beat <= '0;
      end else if (rd_ready) begin
         if (look_beat == LAST_BEAT) begin
            look_beat <= '0;
            look_addr <= look_addr + 1'b1;
            remain    <= remain - 1'b1;
         end else begin
            look_beat <= look_beat + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfg_frame_engine.sv
module cfg_frame_engine
   import cfe_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int FRAME_BEATS = 4,
   parameter int STORE_DEPTH = 8,
   parameter int CNT_W       = 32,
   localparam int BEAT_W     = 4 * WORD_W,
   localparam int FRAME_W    = BEAT_W * FRAME_BEATS,
   localparam int BSEL_W     = (FRAME_BEATS > 1) ? $clog2(FRAME_BEATS) : 1,
   localparam int LIMS_W     = NUM_BT * IDX_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIMS_W-1:0] frame_limits,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_code,
   input  logic              frame_addr_wr,
   input  logic [ADDR_W-1:0] frame_addr_in,
   output logic [ADDR_W-1:0] frame_addr,
   input  logic              beat_valid,
   input  logic [BEAT_W-1:0] beat_data,
   input  logic              count_wr,
   input  logic [CNT_W-1:0]  count_data,
   input  logic              one_frame_wr,
   input  logic [ADDR_W-1:0] one_frame_addr,
   output logic              busy,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [BEAT_W-1:0] rd_data
);
   if (FRAME_BEATS < 1) begin : g_bad_beats
      $error("FRAME_BEATS must be at least 1");
   end
   if (STORE_DEPTH < 2 || (STORE_DEPTH & (STORE_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("STORE_DEPTH must be a power of two of at least 2");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 1..32");
   end

   logic configured, row_on, wr_en, rd_en;
   assign configured = |frame_limits;

   cfe_mode_ctrl u_mode (
      .clk(clk), .rst_n(rst_n), .configured(configured),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .row_on(row_on), .wr_en(wr_en), .rd_en(rd_en)
   );

   // beat collection
   logic              take, commit;
   logic [BSEL_W-1:0] fill;
   logic [BEAT_W-1:0] fbuf [FRAME_BEATS];
   logic [FRAME_W-1:0] frame_vec;

   assign take   = beat_valid && configured && row_on && wr_en;
   assign commit = take && (fill == BSEL_W'(FRAME_BEATS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      fill <= '0;
      else if (commit) fill <= '0;
      else if (take)   fill <= fill + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (take && !commit) fbuf[fill] <= beat_data;
   end

   always_comb begin
      for (int b = 0; b < FRAME_BEATS; b++) begin
         if (b == FRAME_BEATS - 1) frame_vec[b*BEAT_W +: BEAT_W] = beat_data;
         else                      frame_vec[b*BEAT_W +: BEAT_W] = fbuf[b];
      end
   end

   // frame address
   faddr_t addr_next;

   cfe_addr_step u_step (
      .cur(frame_addr), .limits(frame_limits), .nxt(addr_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                              frame_addr <= '0;
      else if (configured && frame_addr_wr)    frame_addr <= frame_addr_in;
      else if (commit)                         frame_addr <= addr_next;
   end

   // readback
   logic [CNT_W-1:0]  count_frames;
   logic              rb_start;
   faddr_t            rb_addr, look_addr;
   logic [CNT_W-1:0]  rb_frames;
   logic [BSEL_W-1:0] look_beat;
   logic              hit;

   if ((FRAME_BEATS & (FRAME_BEATS - 1)) == 0) begin : g_div_shift
      assign count_frames = count_data >> $clog2(FRAME_BEATS);
   end else begin : g_div_const
      assign count_frames = CNT_W'(count_data / FRAME_BEATS);
   end

   assign rb_start  = configured && row_on && rd_en && (count_wr || one_frame_wr);
   assign rb_addr   = count_wr ? frame_addr : one_frame_addr;
   assign rb_frames = count_wr ? count_frames : CNT_W'(1);

   cfe_frame_store #(
      .BEAT_W(BEAT_W), .FRAME_BEATS(FRAME_BEATS), .DEPTH(STORE_DEPTH)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit), .wr_addr(frame_addr), .wr_frame(frame_vec),
      .rd_addr(look_addr), .rd_beat(look_beat),
      .rd_hit(hit), .rd_data(rd_data)
   );

   cfe_readout #(
      .FRAME_BEATS(FRAME_BEATS), .CNT_W(CNT_W)
   ) u_rdout (
      .clk(clk), .rst_n(rst_n),
      .start(rb_start), .start_addr(rb_addr), .n_frames(rb_frames),
      .hit(hit), .rd_ready(rd_ready),
      .look_addr(look_addr), .look_beat(look_beat),
      .rd_valid(rd_valid), .busy(busy)
   );
endmodule

// File: rtl/cfe_checks.sv
module cfe_checks
   import cfe_pkg::*;
#(
   parameter int BEAT_W = 128,
   parameter int LIMS_W = NUM_BT * IDX_W
)(
   input logic              clk,
   input logic              rst_n,
   input logic [LIMS_W-1:0] frame_limits,
   input logic              frame_addr_wr,
   input logic              beat_valid,
   input logic [ADDR_W-1:0] frame_addr,
   input logic              busy,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic [BEAT_W-1:0] rd_data
);
   a_r2_unconf_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_limits == '0) |=> $stable(frame_addr));

   a_r4_addr_moves_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_addr_wr && !beat_valid) |=> $stable(frame_addr));

   a_r5_btype_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_addr_wr |=> (frame_addr[ADDR_W-1:IDX_W] >= $past(frame_addr[ADDR_W-1:IDX_W])));

   a_r5_btype_capped: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_addr_wr && frame_addr[ADDR_W-1:IDX_W] <= BT_W'(NUM_BT - 1))
      |=> (frame_addr[ADDR_W-1:IDX_W] <= BT_W'(NUM_BT - 1)));

   a_r10_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_valid);

   a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind cfg_frame_engine cfe_checks #(.BEAT_W(BEAT_W), .LIMS_W(LIMS_W)) u_cfe_checks (
   .clk(clk), .rst_n(rst_n), .frame_limits(frame_limits),
   .frame_addr_wr(frame_addr_wr), .beat_valid(beat_valid),
   .frame_addr(frame_addr), .busy(busy), .rd_valid(rd_valid),
   .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/test_cfg_frame_engine.sv
module test_cfg_frame_engine;
   localparam int FB    = 4;
   localparam int DEPTH = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [139:0] frame_limits = '0;
   logic         cmd_valid = 1'b0;
   logic [4:0]   cmd_code = '0;
   logic         frame_addr_wr = 1'b0;
   logic [22:0]  frame_addr_in = '0;
   logic [22:0]  frame_addr;
   logic         beat_valid = 1'b0;
   logic [127:0] beat_data = '0;
   logic         count_wr = 1'b0;
   logic [31:0]  count_data = '0;
   logic         one_frame_wr = 1'b0;
   logic [22:0]  one_frame_addr = '0;
   logic         busy, rd_valid;
   logic         rd_ready = 1'b1;
   logic [127:0] rd_data;

   int checks = 0;
   int errors = 0;

   logic         m_v   [DEPTH];
   logic [22:0]  m_tag [DEPTH];
   logic [31:0]  m_seed[DEPTH];
   logic [19:0]  lim   [7];
   logic [127:0] cap [$];
   logic [127:0] expq [$];

   always #4 clk = ~clk;

   cfg_frame_engine #(.FRAME_BEATS(FB), .STORE_DEPTH(DEPTH)) i_cfg_frame_engine (
      .clk(clk), .rst_n(rst_n), .frame_limits(frame_limits),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .frame_addr_wr(frame_addr_wr), .frame_addr_in(frame_addr_in),
      .frame_addr(frame_addr), .beat_valid(beat_valid), .beat_data(beat_data),
      .count_wr(count_wr), .count_data(count_data),
      .one_frame_wr(one_frame_wr), .one_frame_addr(one_frame_addr),
      .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
   );

   always @(negedge clk) if (rd_valid && rd_ready) cap.push_back(rd_data);

   function automatic logic [127:0] pat(input logic [31:0] seed, input int b);
      return {seed, 32'(b), seed ^ 32'hC0DE_0000, ~seed};
   endfunction

   function automatic logic [22:0] step(input logic [22:0] f);
      logic [20:0] ni;
      logic [2:0]  bt;
      bt = f[22:20];
      ni = {1'b0, f[19:0]} + 21'd1;
      if (ni > {1'b0, (bt < 3'd7) ? lim[bt] : 20'd0})
         return {(bt >= 3'd6) ? bt : bt + 3'd1, 20'd0};
      return {bt, ni[19:0]};
   endfunction

   task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic set_limits();
      for (int k = 0; k < 7; k++) frame_limits[k*20 +: 20] = lim[k];
   endtask

   task automatic cmd(input logic [4:0] c);
      cmd_valid = 1'b1; cmd_code = c; tick(); cmd_valid = 1'b0;
   endtask

   task automatic set_addr(input logic [22:0] a);
      frame_addr_wr = 1'b1; frame_addr_in = a; tick(); frame_addr_wr = 1'b0;
   endtask

   task automatic beats(input logic [31:0] seed, input int first, input int n);
      for (int b = first; b < first + n; b++) begin
         beat_valid = 1'b1; beat_data = pat(seed, b); tick();
      end
      beat_valid = 1'b0;
   endtask

   task automatic model_commit(input logic [22:0] a, input logic [31:0] seed);
      m_v[a[2:0]] = 1'b1; m_tag[a[2:0]] = a; m_seed[a[2:0]] = seed;
   endtask

   task automatic build_exp(input logic [22:0] start, input int n);
      expq.delete();
      for (int i = 0; i < n; i++) begin
         logic [22:0] a;
         a = start + 23'(i);
         if (m_v[a[2:0]] && m_tag[a[2:0]] == a)
            for (int b = 0; b < FB; b++) expq.push_back(pat(m_seed[a[2:0]], b));
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
      #1;
   endtask

   task automatic cmp_stream(input string req);
      chk(cap.size() == expq.size(), req, 128'(cap.size()), 128'(expq.size()));
      if (cap.size() == expq.size())
         foreach (cap[i]) chk(cap[i] == expq[i], req, cap[i], expq[i]);
   endtask

   task automatic count_rb(input logic [31:0] n, input string req);
      cap.delete();
      count_wr = 1'b1; count_data = n; tick(); count_wr = 1'b0;
      wait_idle();
      cmp_stream(req);
   endtask

   task automatic one_rb(input logic [22:0] a, input string req);
      cap.delete();
      one_frame_wr = 1'b1; one_frame_addr = a; tick(); one_frame_wr = 1'b0;
      wait_idle();
      cmp_stream(req);
   endtask

   task automatic send_frame(input logic [31:0] seed, input string req);
      logic [22:0] a;
      a = frame_addr;
      beats(seed, 0, FB);
      model_commit(a, seed);
      chk(frame_addr == step(a), req, 128'(frame_addr), 128'(step(a)));
   endtask

   task automatic t_reset();
      chk(rd_valid == 1'b0, "R1 rd_valid", 128'(rd_valid), 128'(0));
      chk(busy == 1'b0, "R1 busy", 128'(busy), 128'(0));
      chk(frame_addr == '0, "R1 frame_addr", 128'(frame_addr), 128'(0));
   endtask

   task automatic t_unconfigured();
      cmd(5'd2); cmd(5'd1); cmd(5'd4);
      set_addr(23'h5);
      chk(frame_addr == '0, "R2 addr write ignored", 128'(frame_addr), 128'(0));
      beats(32'h1, 0, FB);
      chk(frame_addr == '0, "R2 beats ignored", 128'(frame_addr), 128'(0));
      one_frame_wr = 1'b1; one_frame_addr = '0; tick(); one_frame_wr = 1'b0;
      chk(busy == 1'b0, "R2 trigger ignored", 128'(busy), 128'(0));
      lim[0] = 20'd2; lim[1] = 20'd1;
      set_limits();
      tick();
      // the earlier commands must not have stuck: beats still refused
      beats(32'h2, 0, FB);
      chk(frame_addr == '0, "R2 commands ignored", 128'(frame_addr), 128'(0));
   endtask

   task automatic t_write_gating();
      cmd(5'd1);
      beats(32'h10, 0, FB);
      chk(frame_addr == '0, "R3 row off refuses", 128'(frame_addr), 128'(0));
      cmd(5'd2);
      beats(32'h11, 0, 2);
      cmd(5'd3);
      beats(32'h99, 0, 2);
      chk(frame_addr == '0, "R4 partial no commit", 128'(frame_addr), 128'(0));
      cmd(5'd2);
      beats(32'h11, 2, 2);
      model_commit(23'h0, 32'h11);
      chk(frame_addr == 23'h1, "R4 commit after gap", 128'(frame_addr), 128'(1));
      cmd(5'd5);
      beats(32'h12, 0, FB);
      chk(frame_addr == 23'h1, "R3 park clears write", 128'(frame_addr), 128'(1));
      cmd(5'd6); cmd(5'd0); cmd(5'd31);
      beats(32'h13, 0, FB);
      chk(frame_addr == 23'h1, "R3 unknown codes", 128'(frame_addr), 128'(1));
      cmd(5'd1);
   endtask

   task automatic t_addr_step();
      send_frame(32'h21, "R5 index step");
      send_frame(32'h22, "R5 roll to type 1");
      send_frame(32'h23, "R5 index step type 1");
      send_frame(32'h24, "R5 roll to type 2");
      send_frame(32'h25, "R5 zero limit roll");
      chk(frame_addr == 23'h300000, "R5 at type 3", 128'(frame_addr), 128'h300000);
      set_addr(23'h600005);
      send_frame(32'h26, "R5 type 6 saturates");
      chk(frame_addr == 23'h600000, "R5 type 6 value", 128'(frame_addr), 128'h600000);
   endtask

   task automatic t_count_readback();
      set_addr(23'h0);
      cap.delete();
      count_wr = 1'b1; count_data = 32'd35; tick(); count_wr = 1'b0;
      chk(busy == 1'b0, "R6 read enable required", 128'(busy), 128'(0));
      cmd(5'd4);
      build_exp(23'h0, 8);
      count_rb(32'd35, "R8 range with holes");
      chk(frame_addr == 23'h0, "R6 addr kept", 128'(frame_addr), 128'(0));
      set_addr(23'h100000);
      build_exp(23'h100000, 2);
      count_rb(32'd8, "R8 aliased entry skipped");
      build_exp(23'h100000, 0);
      count_rb(32'd3, "R6 short count");
   endtask

   task automatic t_single_readback();
      build_exp(23'h600005, 1);
      one_rb(23'h600005, "R7 single frame");
      build_exp(23'h3, 1);
      one_rb(23'h3, "R7 empty address");
   endtask

   task automatic t_stall_and_busy();
      logic [127:0] held;
      build_exp(23'h200000, 1);
      cap.delete();
      rd_ready = 1'b0;
      one_frame_wr = 1'b1; one_frame_addr = 23'h200000; tick(); one_frame_wr = 1'b0;
      @(negedge clk);
      held = rd_data;
      chk(rd_valid == 1'b1, "R9 valid during stall", 128'(rd_valid), 128'(1));
      tick(); tick();
      chk(rd_data == held && rd_valid, "R9 data held", rd_data, held);
      one_frame_wr = 1'b1; one_frame_addr = 23'h600005; tick(); one_frame_wr = 1'b0;
      for (int i = 0; i < 40 && busy; i++) begin
         rd_ready = ~rd_ready; tick();
      end
      rd_ready = 1'b1;
      wait_idle();
      cmp_stream("R10 second trigger ignored");
   endtask

   task automatic t_reset_clears();
      beats(32'h30, 0, 2);
      rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
      for (int k = 0; k < DEPTH; k++) m_v[k] = 1'b0;
      t_reset();
      cmd(5'd2); cmd(5'd1); cmd(5'd4);
      beats(32'h31, 0, 2);
      chk(frame_addr == '0, "R1 partial frame dropped", 128'(frame_addr), 128'(0));
      beats(32'h31, 2, 2);
      model_commit(23'h0, 32'h31);
      chk(frame_addr == 23'h1, "R1 fresh frame", 128'(frame_addr), 128'(1));
      build_exp(23'h600005, 1);
      one_rb(23'h600005, "R1 store cleared");
      build_exp(23'h0, 1);
      one_rb(23'h0, "R1 new frame readable");
   endtask

   initial begin
      for (int k = 0; k < DEPTH; k++) m_v[k] = 1'b0;
      for (int k = 0; k < 7; k++) lim[k] = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      #1;
      t_reset();
      t_unconfigured();
      t_write_gating();
      t_addr_step();
      t_count_readback();
      t_single_readback();
      t_stall_and_busy();
      t_reset_clears();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule